// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block owns the chip-select lines of an SPI master. Software picks one line by index, gives every line an inactive level (a line is asserted at the opposite level, so each line has its own polarity), and picks one of three behaviours: a select pulse around every frame, a select held across frames, or no hardware select at all. Four 8-bit delays, counted in serial-clock ticks, set the time from select to the first clock, from the last clock to release, the shortest time a line stays inactive, and the gap between frames while a select is held.

The shift engine raises a frame request. It waits for the go signal, clocks the frame while go is high, and pulses frame done after its last clock edge. A single-cycle tick input marks each serial-clock period, and every delay counter advances only on that tick. The configuration port is a plain write strobe with an address, plus a read data bus that decodes without a clock.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset the select index reads 0, the idle-level register reads all ones on implemented lines, the mode reads 0, the edge-delay register (address 3) reads 0x00010001 and the spacing register (address 4) reads 0x00000001. Every line sits at its idle level and go is low.
- R2: The idle-level register (address 1) keeps one bit per implemented line. Bits above NUM_LINES read back as zero, so writing all ones reveals the line count.
- R3: While a frame holds the select, the latched line drives the inverse of its idle bit and every other line stays at its idle bit. At most one line differs from its idle level.
- R4: Lead delay is bits 7:0 of address 3. With the tick held high, go rises lead+1 clocks after chip select asserts.
- R5: Delay counters advance only on cycles where the tick is high. With the tick low, the sequencer stays in its current delay phase.
- R6: Trail delay is bits 23:16 of address 3. With the tick held high, chip select stays asserted trail+1 clocks after the clock edge that samples frame done, and go falls at that edge.
- R7: In automatic mode (mode value 0, address 2), the inactive time is bits 7:0 of address 4. With the tick high and a request already waiting, a line stays released for inactive+2 clocks between frames.
- R8: In hold mode (mode value 2), chip select stays asserted between frames. Frame spacing is bits 23:16 of address 4. With a request waiting, go is low for trail+gap+3 clocks between frames.
- R9: A held select is released, and the inactive time starts, when the mode leaves hold or the select index (address 0, bits 4:0) changes.
- R10: In off mode (mode value 3), no line ever leaves its idle level, but frames still get go with the same lead and trail timing.
- R11: The select index is latched when a frame starts, so a write during the frame does not move the select. An index of NUM_LINES or above asserts no line.
- R12: Writing all ones to address 3 reads back 0x00FF00FF. Bits outside the two 8-bit fields are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| sclk_tick | input | 1 | One-cycle pulse per serial-clock period |
| frame_req | input | 1 | Shift engine asks to start a frame |
| frame_done | input | 1 | Shift engine finished its last clock edge |
| frame_go | output | 1 | Shift engine may clock the frame |
| cs_lines | output | NUM_LINES | Chip-select line levels |

## Verification
The bench builds the block with NUM_LINES=4 and DLY_W=8. Four lines are fewer than the 32-bit register width, so the bench can reach both the zero read-back of unimplemented idle bits and an out-of-range select index. The 8-bit delay width is enough for the read-back masking of the delay fields. The test delays stay small, so every lead, trail, inactive and gap count can be checked to the exact clock with the tick held high. One test holds the tick low to show a phase that does not advance.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;
    localparam int MAX_LINES = 32;
    localparam int IDX_W     = 5;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int HI_LSB    = 16;

    localparam logic [ADDR_W-1:0] A_SELECT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IDLELVL = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE    = 3'd2;
    localparam logic [ADDR_W-1:0] A_EDGEDLY = 3'd3;
    localparam logic [ADDR_W-1:0] A_SPACING = 3'd4;

    typedef enum logic [1:0] {
        CSM_AUTO = 2'd0,
        CSM_RSVD = 2'd1,
        CSM_HOLD = 2'd2,
        CSM_OFF  = 2'd3
    } cs_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_GAP,
        ST_HELD,
        ST_RELEASE
    } seq_state_e;
endpackage

// File: rtl/spi_cs_seq_regs.sv
module spi_cs_seq_regs
    import spi_cs_seq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DLY_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    output logic [IDX_W-1:0]      sel,
    output logic [NUM_LINES-1:0]  idle_lvl,
    output cs_mode_e              mode,
    output logic [DLY_W-1:0]      lead,
    output logic [DLY_W-1:0]      trail,
    output logic [DLY_W-1:0]      inact,
    output logic [DLY_W-1:0]      gap
);
    typedef struct packed {
        logic [IDX_W-1:0]     sel;
        logic [NUM_LINES-1:0] lvl;
        cs_mode_e             mode;
        logic [DLY_W-1:0]     lead;
        logic [DLY_W-1:0]     trail;
        logic [DLY_W-1:0]     inact;
        logic [DLY_W-1:0]     gap;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (addr)
                A_SELECT:  cfg_d.sel  = wdata[IDX_W-1:0];
                A_IDLELVL: cfg_d.lvl  = wdata[NUM_LINES-1:0];
                A_MODE:    cfg_d.mode = cs_mode_e'(wdata[1:0]);
                A_EDGEDLY: begin
                    cfg_d.lead  = wdata[DLY_W-1:0];
                    cfg_d.trail = wdata[HI_LSB +: DLY_W];
                end
                A_SPACING: begin
                    cfg_d.inact = wdata[DLY_W-1:0];
                    cfg_d.gap   = wdata[HI_LSB +: DLY_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sel   <= '0;
            cfg_q.lvl   <= '1;
            cfg_q.mode  <= CSM_AUTO;
            cfg_q.lead  <= DLY_W'(1);
            cfg_q.trail <= DLY_W'(1);
            cfg_q.inact <= DLY_W'(1);
            cfg_q.gap   <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_SELECT:  rdata = REG_W'(cfg_q.sel);
            A_IDLELVL: rdata = REG_W'(cfg_q.lvl);
            A_MODE:    rdata = REG_W'(cfg_q.mode);
            A_EDGEDLY: begin
                rdata[DLY_W-1:0]       = cfg_q.lead;
                rdata[HI_LSB +: DLY_W] = cfg_q.trail;
            end
            A_SPACING: begin
                rdata[DLY_W-1:0]       = cfg_q.inact;
                rdata[HI_LSB +: DLY_W] = cfg_q.gap;
            end
            default: rdata = '0;
        endcase
    end

    assign sel      = cfg_q.sel;
    assign idle_lvl = cfg_q.lvl;
    assign mode     = cfg_q.mode;
    assign lead     = cfg_q.lead;
    assign trail    = cfg_q.trail;
    assign inact    = cfg_q.inact;
    assign gap      = cfg_q.gap;

    generate
        if (NUM_LINES < REG_W) begin : g_unimpl_chk
            AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (addr == A_IDLELVL) |-> (rdata[REG_W-1:NUM_LINES] == '0)); // R2
        end
    endgenerate
endmodule

// File: rtl/spi_cs_seq_fsm.sv
module spi_cs_seq_fsm
    import spi_cs_seq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic              done,
    input  cs_mode_e          mode,
    input  logic [IDX_W-1:0]  sel,
    input  logic [DLY_W-1:0]  lead,
    input  logic [DLY_W-1:0]  trail,
    input  logic [DLY_W-1:0]  inact,
    input  logic [DLY_W-1:0]  gap,
    output logic              go,
    output logic              seq_on,
    output logic [IDX_W-1:0]  act_sel
);
    typedef struct packed {
        seq_state_e       st;
        logic [DLY_W-1:0] cnt;
        logic [IDX_W-1:0] asel;
    } seq_t;

    seq_t s_d, s_q;
    logic expired;
    logic count_down;

    always_comb begin
        s_d        = s_q;
        expired    = (s_q.cnt == '0);
        count_down = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.st   = ST_LEAD;
                    s_d.cnt  = lead;
                    s_d.asel = sel;
                end
            end
            ST_LEAD: begin
                if (expired) s_d.st = ST_XFER;
                else         count_down = 1'b1;
            end
            ST_XFER: begin
                if (done) begin
                    s_d.st  = ST_TRAIL;
                    s_d.cnt = trail;
                end
            end
            ST_TRAIL: begin
                if (expired) begin
                    if (mode == CSM_HOLD) begin
                        s_d.st  = ST_GAP;
                        s_d.cnt = gap;
                    end else begin
                        s_d.st  = ST_RELEASE;
                        s_d.cnt = inact;
                    end
                end else begin
                    count_down = 1'b1;
                end
            end
            ST_GAP: begin
                if (expired) s_d.st = ST_HELD;
                else         count_down = 1'b1;
            end
            ST_HELD: begin
                if ((mode != CSM_HOLD) || (sel != s_q.asel)) begin
                    s_d.st  = ST_RELEASE;
                    s_d.cnt = inact;
                end else if (req) begin
                    s_d.st = ST_XFER;
                end
            end
            ST_RELEASE: begin
                if (expired) s_d.st = ST_IDLE;
                else         count_down = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (count_down && tick) s_d.cnt = s_q.cnt - DLY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.cnt  <= '0;
            s_q.asel <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign go      = (s_q.st == ST_XFER);
    assign seq_on  = (s_q.st == ST_LEAD) || (s_q.st == ST_XFER) || (s_q.st == ST_TRAIL)
                   || (s_q.st == ST_GAP) || (s_q.st == ST_HELD);
    assign act_sel = s_q.asel;

    AST_GO_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go) |-> $past(seq_on)); // R4
    AST_DELAY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_LEAD && !tick && s_q.cnt != '0) |=> (s_q.st == ST_LEAD)); // R5
    AST_DONE_CLOSES_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (go && done) |=> !go); // R6
    AST_INDEX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go)) |-> $stable(act_sel)); // R11
endmodule

// File: rtl/spi_cs_seq_drive.sv
module spi_cs_seq_drive
    import spi_cs_seq_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [IDX_W-1:0]      act_sel,
    input  logic [NUM_LINES-1:0]  idle_lvl,
    output logic [NUM_LINES-1:0]  cs_lines
);
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            assign cs_lines[i] = idle_lvl[i] ^ (en && (act_sel == IDX_W'(i)));
        end
    endgenerate

    AST_ONE_LINE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_lines ^ idle_lvl)); // R3
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
    import spi_cs_seq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DLY_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  sclk_tick,
    input  logic                  frame_req,
    input  logic                  frame_done,
    output logic                  frame_go,
    output logic [NUM_LINES-1:0]  cs_lines
);
    logic [IDX_W-1:0]     sel;
    logic [NUM_LINES-1:0] idle_lvl;
    cs_mode_e             mode;
    logic [DLY_W-1:0]     lead, trail, inact, gap;
    logic                 seq_on;
    logic [IDX_W-1:0]     act_sel;
    logic                 drive_en;

    spi_cs_seq_regs #(.NUM_LINES(NUM_LINES), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .sel(sel), .idle_lvl(idle_lvl), .mode(mode),
        .lead(lead), .trail(trail), .inact(inact), .gap(gap)
    );

    spi_cs_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(sclk_tick), .req(frame_req), .done(frame_done),
        .mode(mode), .sel(sel), .lead(lead), .trail(trail), .inact(inact), .gap(gap),
        .go(frame_go), .seq_on(seq_on), .act_sel(act_sel)
    );

    assign drive_en = seq_on && (mode != CSM_OFF);

    spi_cs_seq_drive #(.NUM_LINES(NUM_LINES)) u_drive (
        .clk(clk), .rst_n(rst_n), .en(drive_en), .act_sel(act_sel),
        .idle_lvl(idle_lvl), .cs_lines(cs_lines)
    );

    AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CSM_OFF) |-> (cs_lines == idle_lvl)); // R10
    AST_GO_HAS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && mode != CSM_OFF && act_sel < IDX_W'(NUM_LINES)) |-> (cs_lines != idle_lvl)); // R3
endmodule

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;
    localparam int NL = 4;
    localparam int TV_N = 4;
    localparam int TV_SEL  [TV_N] = '{2, 0, 3, 1};
    localparam int TV_LEAD [TV_N] = '{0, 3, 5, 1};
    localparam int TV_TRL  [TV_N] = '{3, 0, 2, 1};
    localparam int TV_LVL  [TV_N] = '{4'hF, 4'hE, 4'h5, 4'h0};
    localparam int TV_ACT  [TV_N] = '{4'hB, 4'hF, 4'hD, 4'h2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic sclk_tick = 1'b1;
    logic frame_req = 1'b0;
    logic frame_done = 1'b0;
    logic frame_go;
    logic [NL-1:0] cs_lines;

    int checks = 0;
    int fails = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    spi_cs_sequencer #(.NUM_LINES(NL), .DLY_W(8)) u_spi_cs_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sclk_tick(sclk_tick),
        .frame_req(frame_req), .frame_done(frame_done), .frame_go(frame_go),
        .cs_lines(cs_lines)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic start_frame(output int n);
        frame_req = 1'b1; n = 0;
        @(negedge clk);
        while (frame_go !== 1'b1) begin n++; @(negedge clk); end
        frame_req = 1'b0;
    endtask

    task automatic end_frame(input logic [NL-1:0] idle, output int n);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0; n = 0;
        while (cs_lines !== idle) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cs idle", 32'(cs_lines), 32'hF);
        chk("R1 go low", 32'(frame_go), 0);
        rd(3'd0, r); chk("R1 select", r, 0);
        rd(3'd1, r); chk("R1 idle level", r, 32'hF);
        rd(3'd2, r); chk("R1 mode", r, 0);
        rd(3'd3, r); chk("R1 edge delays", r, 32'h00010001);
        rd(3'd4, r); chk("R1 spacing", r, 32'h00000001);
        @(negedge clk);

        // R2 line discovery
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, r); chk("R2 unimplemented bits zero", r, 32'h0000000F);
        @(negedge clk);

        // R12 field masking
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, r); chk("R12 edge delay fields", r, 32'h00FF00FF);
        @(negedge clk);

        // R3 R4 R6 vector table
        for (int i = 0; i < TV_N; i++) begin
            wr(3'd1, 32'(TV_LVL[i]));
            wr(3'd0, 32'(TV_SEL[i]));
            wr(3'd3, 32'(TV_LEAD[i]) | (32'(TV_TRL[i]) << 16));
            repeat (4) @(negedge clk);
            chk("R3 idle pattern", 32'(cs_lines), 32'(TV_LVL[i]));
            start_frame(n);
            chk("R4 lead clocks", 32'(n), 32'(TV_LEAD[i] + 1));
            chk("R3 active pattern", 32'(cs_lines), 32'(TV_ACT[i]));
            @(negedge clk);
            end_frame(4'(TV_LVL[i]), n);
            chk("R6 trail clocks", 32'(n), 32'(TV_TRL[i] + 1));
            repeat (4) @(negedge clk);
        end

        // R7 inactive time with request waiting
        wr(3'd1, 32'hF);
        wr(3'd0, 32'd0);
        wr(3'd3, 32'h00010001);
        wr(3'd4, 32'h00000003);
        repeat (4) @(negedge clk);
        start_frame(n);
        @(negedge clk);
        end_frame(4'hF, n);
        frame_req = 1'b1; n = 0;
        while (cs_lines === 4'hF) begin n++; @(negedge clk); end
        chk("R7 inactive clocks", 32'(n), 32'd5);
        while (frame_go !== 1'b1) @(negedge clk);
        frame_req = 1'b0;
        // R11 select write during frame
        wr(3'd0, 32'd1);
        chk("R11 select latched", 32'(cs_lines), 32'hE);
        end_frame(4'hF, n);
        repeat (8) @(negedge clk);

        // R5 tick low stalls lead
        wr(3'd0, 32'd2);
        wr(3'd3, 32'h00010002);
        wr(3'd4, 32'h00000001);
        repeat (3) @(negedge clk);
        sclk_tick = 1'b0;
        frame_req = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 go held without tick", 32'(frame_go), 0);
        chk("R5 select asserted", 32'(cs_lines), 32'hB);
        sclk_tick = 1'b1;
        @(negedge clk);
        n = 0;
        while (frame_go !== 1'b1) begin n++; @(negedge clk); end
        frame_req = 1'b0;
        chk("R5 lead resumes on tick", 32'(n), 32'd2);
        end_frame(4'hF, n);
        repeat (6) @(negedge clk);

        // R8 hold mode
        wr(3'd3, 32'h00010001);
        wr(3'd4, 32'h00020001);
        wr(3'd2, 32'd2);
        repeat (3) @(negedge clk);
        start_frame(n);
        frame_done = 1'b1; frame_req = 1'b1;
        @(negedge clk);
        frame_done = 1'b0; n = 0; r = 0;
        while (frame_go !== 1'b1) begin
            n++;
            if (cs_lines !== 4'hB) r = 1;
            @(negedge clk);
        end
        frame_req = 1'b0;
        chk("R8 go low between held frames", 32'(n), 32'd6);
        chk("R8 select never dropped", r, 0);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 held after frame", 32'(cs_lines), 32'hB);
        // R9 release on mode change
        wr(3'd2, 32'd0);
        @(negedge clk);
        chk("R9 release on mode exit", 32'(cs_lines), 32'hF);
        repeat (6) @(negedge clk);

        // R9 release on select change
        wr(3'd2, 32'd2);
        repeat (2) @(negedge clk);
        start_frame(n);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 held before select write", 32'(cs_lines), 32'hB);
        wr(3'd0, 32'd1);
        @(negedge clk);
        chk("R9 release on select change", 32'(cs_lines), 32'hF);
        repeat (6) @(negedge clk);

        // R10 off mode
        wr(3'd2, 32'd3);
        repeat (2) @(negedge clk);
        start_frame(n);
        chk("R10 go still granted", 32'(n), 32'd2);
        chk("R10 no line asserted", 32'(cs_lines), 32'hF);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 idle after frame", 32'(cs_lines), 32'hF);

        // R11 out-of-range index
        wr(3'd2, 32'd0);
        wr(3'd0, 32'd6);
        repeat (2) @(negedge clk);
        start_frame(n);
        chk("R11 out of range asserts none", 32'(cs_lines), 32'hF);
        end_frame(4'hF, n);
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule